// File: doc/BRIEF.md
# Offset-Tracking Modular Lane Rotator

This block rotates a wide vector of parallel soft-value lanes by a variable number of lanes. The rotation wraps modulo the lane count, which by default is 30, not a power of two. It serves a decoder for codes whose parity check matrix is assembled from cyclically shifted identity submatrices. Each memory word needs to reach the processing lanes in a particular cyclic alignment. After processing, the word goes back to memory in that same alignment, so no inverse rotation is ever applied.

To allow this, the block keeps a small table with one entry per memory address. Each entry holds the rotation that the data stored at that address already carries. On every transfer the block reads the entry and computes the extra rotation still needed, which is (target - stored) modulo the lane count. It applies that extra rotation and then records the target as the new stored offset. A plain control pin clears the whole table at the start of a codeword, when the channel values are loaded unshifted.

Data enters and leaves over valid/ready handshakes with a single registered output stage. A transfer is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its data and the input is stalled. Only an accepted transfer touches the offset table.

Top module: `offset_rotator`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every stored offset is 0, so a first transfer to any address is rotated by its full target.
- R2: Lane k occupies bits [k*LANE_W +: LANE_W] of a data bus. A rotation by r gives output lane i = input lane (i + r) mod LANES.
- R3: The rotation applied to an accepted transfer is (in_target - stored offset of in_addr) mod LANES, a value from 0 to LANES-1.
- R4: An accepted transfer replaces the stored offset of in_addr with in_target and leaves every other address unchanged.
- R5: The rotated result appears on `out_data` with `out_valid` high in the cycle after acceptance. It is dropped after a cycle in which `out_ready` is high and no new transfer is accepted.
- R6: `in_ready` equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, `out_data` stays stable, and a transfer that is offered but not accepted leaves the offset table unchanged.
- R7: `clear_offsets` high at a clock edge sets every stored offset to 0. A transfer accepted in the same cycle is rotated with the offset stored before the clear, and the clear takes precedence over that transfer's offset update.
- R8: in_target must lie in 0..LANES-1. The extreme cases behave modularly: target LANES-1 over stored 0 rotates by LANES-1, and target 0 over stored LANES-1 rotates by 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_offsets | input | 1 | Clears every stored offset at the next edge |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken this cycle |
| in_addr | input | ADDR_W | Memory address the input word belongs to |
| in_target | input | SHIFT_W | Alignment required for this word, 0..LANES-1 |
| in_data | input | LANES*LANE_W | Lane vector as currently stored |
| out_valid | output | 1 | Rotated result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | LANES*LANE_W | Lane vector in the target alignment |

## Verification
A result is due exactly one clock edge after its acceptance edge. The bench drives inputs on the falling edge and samples `out_data` and `out_valid` at the next falling edge, after one register stage. Offset updates also take effect at the acceptance edge, so the bench keeps a model table that it updates at acceptance. Each following transfer is then checked against the rotation the model predicts. The stall and clear cases sample at every falling edge of the stalled or cleared window, so a result or update that arrives early or late shows up as a mismatch.

// File: rtl/offrot_pkg.sv
package offrot_pkg;
  localparam int LANES_DEF  = 30;
  localparam int LANE_W_DEF = 9;
  localparam int DEPTH_DEF  = 16;

  // Source lane feeding lane i when one stage rotates by sh lanes
  function automatic int lane_src(input int i, input int sh, input int n);
    return (i + sh) % n;
  endfunction
endpackage

// File: rtl/offrot_table.sv
module offrot_table #(
  parameter int DEPTH   = 16,
  parameter int SHIFT_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [SHIFT_W-1:0] rd_off,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SHIFT_W-1:0] wr_off
);
  logic [SHIFT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (clear) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_off;
    end
  end

  assign rd_off = mem[rd_addr];

  // R7: after a clear every entry reads back as zero
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> rd_off == '0);

  // R4: a write without clear lands at its address
  assert_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> mem[$past(wr_addr)] == $past(wr_off));
endmodule

// File: rtl/offrot_shiftcalc.sv
module offrot_shiftcalc #(
  parameter int LANES   = 30,
  parameter int SHIFT_W = 5
) (
  input  logic [SHIFT_W-1:0] target,
  input  logic [SHIFT_W-1:0] stored,
  output logic [SHIFT_W-1:0] rel
);
  logic [SHIFT_W:0] diff;

  always_comb begin
    diff = {1'b0, target} - {1'b0, stored};
    if (diff[SHIFT_W]) rel = SHIFT_W'(diff + (SHIFT_W+1)'(LANES));
    else               rel = diff[SHIFT_W-1:0];
  end
endmodule

// File: rtl/offrot_barrel.sv
module offrot_barrel #(
  parameter int LANES   = 30,
  parameter int LANE_W  = 9,
  parameter int SHIFT_W = 5
) (
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [SHIFT_W-1:0]      amt,
  output logic [LANES*LANE_W-1:0] dout
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] st [SHIFT_W+1];

  assign st[0] = din;

  for (genvar s = 0; s < SHIFT_W; s++) begin : g_stage
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int SRC = offrot_pkg::lane_src(i, 1 << s, LANES);
      assign st[s+1][i*LANE_W +: LANE_W] =
        amt[s] ? st[s][SRC*LANE_W +: LANE_W] : st[s][i*LANE_W +: LANE_W];
    end
  end

  assign dout = st[SHIFT_W];
endmodule

// File: rtl/offset_rotator.sv
module offset_rotator #(
  parameter int LANES   = offrot_pkg::LANES_DEF,
  parameter int LANE_W  = offrot_pkg::LANE_W_DEF,
  parameter int DEPTH   = offrot_pkg::DEPTH_DEF,
  parameter int SHIFT_W = $clog2(LANES),
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_offsets,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [SHIFT_W-1:0]      in_target,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic               accept;
  logic [SHIFT_W-1:0] stored_off;
  logic [SHIFT_W-1:0] rel_shift;
  logic [DATA_W-1:0]  rotated;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  offrot_table #(.DEPTH(DEPTH), .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_offsets),
    .rd_addr (in_addr),
    .rd_off  (stored_off),
    .wr_en   (accept),
    .wr_addr (in_addr),
    .wr_off  (in_target)
  );

  offrot_shiftcalc #(.LANES(LANES), .SHIFT_W(SHIFT_W)) u_calc (
    .target (in_target),
    .stored (stored_off),
    .rel    (rel_shift)
  );

  offrot_barrel #(.LANES(LANES), .LANE_W(LANE_W), .SHIFT_W(SHIFT_W)) u_rot (
    .din  (in_data),
    .amt  (rel_shift),
    .dout (rotated)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= rotated;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5: an accepted transfer is presented on the next cycle
  assert_valid_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R6: a stalled result holds still
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3: the computed extra rotation stays within the lane count
  assert_rel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (rel_shift < SHIFT_W'(LANES)));

  // R8: offered targets stay within the lane count
  assert_target_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_target < SHIFT_W'(LANES)));
endmodule

// File: tb/offset_rotator_tb.sv
module offset_rotator_tb;
  localparam int L  = 30;
  localparam int W  = 9;
  localparam int D  = 16;
  localparam int SW = 5;
  localparam int AW = 4;
  localparam int DW = L * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear_offsets = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_target = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int model [D];

  always #5 clk = ~clk;

  offset_rotator u_dut (
    .clk(clk), .rst_n(rst_n), .clear_offsets(clear_offsets),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_target(in_target), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [DW-1:0] mk(input int seed);
    logic [DW-1:0] d;
    for (int j = 0; j < L; j++) d[j*W +: W] = W'((j*37 + seed*11 + 5) % 512);
    return d;
  endfunction

  function automatic logic [DW-1:0] rot(input logic [DW-1:0] d, input int r);
    logic [DW-1:0] o;
    for (int i = 0; i < L; i++) o[i*W +: W] = d[((i + r) % L)*W +: W];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int a, input int t, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    in_addr = AW'(a); in_target = SW'(t); in_data = d; in_valid = 1'b1;
    exp = rot(d, (t - model[a] + L) % L);
    model[a] = t;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == exp, req, out_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] da, db, ea, eb, dv;
    for (int k = 0; k < D; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 2'b01);

    // R1: first transfer to each address rotates by its full target
    for (int a = 0; a < D; a++) xfer(a, (a*7 + 3) % L, mk(a), "R1");

    // R5: result dropped after it is consumed
    @(negedge clk);
    chk(!out_valid, "R5", out_valid, 0);

    // R2: lane position mapping, lane j holds j+1, rotate by 1 -> lane0 = 2
    for (int j = 0; j < L; j++) dv[j*W +: W] = W'(j + 1);
    xfer(0, (model[0] + 1) % L, dv, "R2");
    chk(out_data[W-1:0] == 9'd2, "R2", out_data[W-1:0], 9'd2);

    // R3/R4: every (stored, target) pair, across several addresses
    for (int p = 0; p < L; p++) begin
      for (int t = 0; t < L; t++) begin
        xfer((p + t) % D, p, mk(p*L + t), "R4");
        xfer((p + t) % D, t, mk(p*L + t + 7), "R3");
      end
    end

    // R8: modular extremes
    xfer(5, 0, mk(900), "R8");
    xfer(5, L-1, mk(901), "R8");
    xfer(5, 0, mk(902), "R8");

    // R6: back-pressure
    da = mk(1000); db = mk(1001);
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = AW'(2); in_target = SW'(5); in_data = da; in_valid = 1'b1;
    ea = rot(da, (5 - model[2] + L) % L); model[2] = 5;
    @(negedge clk);
    in_target = SW'(9); in_data = db;
    eb = rot(db, (9 - 5 + L) % L);
    chk(!in_ready, "R6", in_ready, 0);
    for (int c = 0; c < 3; c++) begin
      chk(out_valid && out_data == ea, "R6", out_data, ea);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model[2] = 9;
    chk(out_valid && out_data == eb, "R6", out_data, eb);

    // R7: clear alone
    xfer(3, 11, mk(1100), "R7");
    xfer(4, 17, mk(1101), "R7");
    @(negedge clk); clear_offsets = 1'b1;
    @(negedge clk); clear_offsets = 1'b0;
    for (int k = 0; k < D; k++) model[k] = 0;
    xfer(3, 6, mk(1102), "R7");
    xfer(4, 17, mk(1103), "R7");

    // R7: clear concurrent with a transfer
    da = mk(1104);
    @(negedge clk);
    in_addr = AW'(4); in_target = SW'(20); in_data = da; in_valid = 1'b1;
    clear_offsets = 1'b1;
    ea = rot(da, 3);
    @(negedge clk);
    in_valid = 1'b0; clear_offsets = 1'b0;
    chk(out_valid && out_data == ea, "R7", out_data, ea);
    for (int k = 0; k < D; k++) model[k] = 0;
    xfer(4, 25, mk(1105), "R7");
    xfer(3, 1, mk(1106), "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule